// File: doc/BRIEF.md
# Partial-Fill Direct-Mapped Instruction Cache

This block sits between a processor's instruction-fetch port and a word-wide memory read port. It keeps a direct-mapped array of lines, each holding four 32-bit words by default. A fetch that hits returns the word from the array. A fetch that misses reads memory from the requested word up to the last word of its line, stores those words, and returns the requested one. Words in the line before the requested one are never read. To make up for this, the stored tag is the full address of the first word loaded, so an earlier word in the same line still misses.

A memory response flagged as unmapped makes the fetch return an all-zero word, which executes as a no-op, and sets a bus-error flag. A bulk isolate input sets every tag and data entry to all ones, which invalidates the whole array. A bypass input sends a fetch straight to memory as a single word read and leaves the array untouched.

The controller is a four-state machine. `ST_IDLE` waits for a request. It goes to `ST_RESP` on a hit, to `ST_FILL` on a miss and to `ST_BYPASS` when bypass is set. `ST_FILL` stays in place while words remain, and goes to `ST_RESP` after the last word of the line or on a memory error. `ST_BYPASS` goes to `ST_RESP` when its single word returns. `ST_RESP` drives the acknowledge for one cycle and always returns to `ST_IDLE`.

Top module: `icache_partial_fill`

## Requirements
- R1: The line index is taken from address bits [LINE_IDX_W+3:4] (bits [11:4] by default), and the word within the line from bits [3:2]. Addresses that differ only above the index share one line and evict each other.
- R2: A fetch hits when address bits [31:4] equal stored tag bits [31:4] and the address is not below the stored tag. On a hit, fetch_ack rises in the cycle after the request is taken, and no memory read is made.
- R3: On a miss, memory is read in ascending word order from the requested word up to word 3 of the line. The first read is at the requested address, so a fetch at word k makes 4-k reads.
- R4: After a fill, the stored tag is the address of the first word loaded. A later word of that line hits. An earlier word misses and refills from its own position.
- R5: On a miss, fetch_ack is asserted in the cycle after the last fill word is accepted, and fetch_data holds the requested word. The memory port keeps mem_addr stable while mem_req waits for mem_ready.
- R6: If mem_err accompanies a returned word, the fetch completes with fetch_data = 0 and fetch_buserr = 1. The fill stops there and the line stays invalid, so a repeat fetch reads memory again.
- R7: A cycle with isolate high sets all tags and data to all ones. Every following fetch misses until its line is refilled.
- R8: After reset, every tag is all ones, fetch_ack, fetch_buserr and mem_req are low, and no line hits until it has been refilled, including the address 0xFFFFFFFC.
- R9: With bypass high, a fetch makes exactly one memory read at its own address and is acknowledged after it. Tags and data are not changed: resident lines still hit, and the bypassed line does not become resident.
- R10: fetch_ack is a one-cycle pulse. The requester holds fetch_req, fetch_addr and bypass steady until fetch_ack, and may present the next request from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_req | input | 1 | Fetch request, held until fetch_ack |
| fetch_addr | input | ADDR_W | Word-aligned fetch address |
| bypass | input | 1 | Send this fetch directly to memory |
| isolate | input | 1 | Bulk invalidate of all tags and data |
| fetch_ack | output | 1 | One-cycle completion pulse |
| fetch_data | output | DATA_W | Fetched word, valid with fetch_ack |
| fetch_buserr | output | 1 | Instruction bus error, valid with fetch_ack |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | ADDR_W | Memory word address |
| mem_ready | input | 1 | Memory word returned this cycle |
| mem_data | input | DATA_W | Returned memory word |
| mem_err | input | 1 | Returned word lies in an unmapped region |

## Verification
The bench builds the block with LINE_IDX_W = 4, so the array has 16 lines and the index sits in bits [7:4]. With that setting, addresses 256 bytes apart collide in one line. This keeps evictions, replacement by an earlier-starting fill, and the reset tag of the top line within a short run. Word selection stays at the default two bits, so partial fills of one to four words are all exercised. Fill latency and read count are checked against the requested word position.

// File: rtl/icache_pf_pkg.sv
package icache_pf_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FILL   = 2'd1,
        ST_BYPASS = 2'd2,
        ST_RESP   = 2'd3
    } icache_state_e;
endpackage

// File: rtl/icache_tag_store.sv
module icache_tag_store #(
    parameter int ADDR_W     = 32,
    parameter int LINE_IDX_W = 8,
    parameter int WORD_SEL_W = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  isolate,
    input  logic [ADDR_W-1:0]     lk_addr,
    output logic                  hit,
    input  logic                  wr_en,
    input  logic [LINE_IDX_W-1:0] wr_idx,
    input  logic [ADDR_W-1:0]     wr_tag
);
    localparam int LINES = 2 ** LINE_IDX_W;
    localparam int LSB   = WORD_SEL_W + 2;

    logic [ADDR_W-1:0] tags [LINES];
    logic [ADDR_W-1:0] cur_tag;

    always_ff @(posedge clk) begin
        if (!rst_n || isolate) begin
            for (int i = 0; i < LINES; i++) tags[i] <= '1;
        end else if (wr_en) begin
            tags[wr_idx] <= wr_tag;
        end
    end

    always_comb begin
        cur_tag = tags[lk_addr[LSB+LINE_IDX_W-1:LSB]];
        hit     = (cur_tag[ADDR_W-1:LSB] == lk_addr[ADDR_W-1:LSB]) && (lk_addr >= cur_tag);
    end

    // R7: the cycle after a bulk invalidate, no aligned address may hit
    p_isolate_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(isolate) && lk_addr[1:0] == 2'b00) |-> !hit);
endmodule

// File: rtl/icache_data_store.sv
module icache_data_store #(
    parameter int DATA_W     = 32,
    parameter int LINE_IDX_W = 8,
    parameter int WORD_SEL_W = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  isolate,
    input  logic                  wr_en,
    input  logic [LINE_IDX_W-1:0] wr_idx,
    input  logic [WORD_SEL_W-1:0] wr_off,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic [LINE_IDX_W-1:0] rd_idx,
    input  logic [WORD_SEL_W-1:0] rd_off,
    output logic [DATA_W-1:0]     rd_data
);
    localparam int LINES = 2 ** LINE_IDX_W;
    localparam int WORDS = 2 ** WORD_SEL_W;

    logic [DATA_W-1:0] words [LINES][WORDS];

    always_ff @(posedge clk) begin
        if (!rst_n || isolate) begin
            for (int i = 0; i < LINES; i++)
                for (int j = 0; j < WORDS; j++)
                    words[i][j] <= '1;
        end else if (wr_en) begin
            words[wr_idx][wr_off] <= wr_data;
        end
    end

    assign rd_data = words[rd_idx][rd_off];
endmodule

// File: rtl/icache_fill_ctrl.sv
module icache_fill_ctrl
    import icache_pf_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int LINE_IDX_W = 8,
    parameter int WORD_SEL_W = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  fetch_req,
    input  logic [ADDR_W-1:0]     fetch_addr,
    input  logic                  bypass,
    input  logic                  hit,
    input  logic [DATA_W-1:0]     rd_word,
    output logic                  fetch_ack,
    output logic [DATA_W-1:0]     fetch_data,
    output logic                  fetch_buserr,
    output logic                  mem_req,
    output logic [ADDR_W-1:0]     mem_addr,
    input  logic                  mem_ready,
    input  logic [DATA_W-1:0]     mem_data,
    input  logic                  mem_err,
    output logic                  tag_we,
    output logic [LINE_IDX_W-1:0] tag_widx,
    output logic [ADDR_W-1:0]     tag_wval,
    output logic                  data_we,
    output logic [LINE_IDX_W-1:0] data_widx,
    output logic [WORD_SEL_W-1:0] data_woff,
    output logic [DATA_W-1:0]     data_wdata
);
    localparam int LSB = WORD_SEL_W + 2;
    localparam logic [WORD_SEL_W-1:0] LAST_OFF = '1;

    icache_state_e         state, state_n;
    logic [ADDR_W-1:0]     req_addr;
    logic [WORD_SEL_W-1:0] word_cnt;
    logic [DATA_W-1:0]     resp_data;
    logic                  resp_err;
    logic                  fill_last;
    logic                  take_miss;

    assign fill_last = mem_ready && (mem_err || word_cnt == LAST_OFF);
    assign take_miss = (state == ST_IDLE) && fetch_req && !bypass && !hit;

    // State register and datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            req_addr  <= '0;
            word_cnt  <= '0;
            resp_data <= '0;
            resp_err  <= 1'b0;
        end else begin
            state <= state_n;
            unique case (state)
                ST_IDLE: if (fetch_req) begin
                    req_addr <= fetch_addr;
                    word_cnt <= fetch_addr[LSB-1:2];
                    if (!bypass && hit) begin
                        resp_data <= rd_word;
                        resp_err  <= 1'b0;
                    end
                end
                ST_FILL: if (mem_ready) begin
                    word_cnt <= word_cnt + 1'b1;
                    if (mem_err) begin
                        resp_data <= '0;
                        resp_err  <= 1'b1;
                    end else if (word_cnt == req_addr[LSB-1:2]) begin
                        resp_data <= mem_data;
                        resp_err  <= 1'b0;
                    end
                end
                ST_BYPASS: if (mem_ready) begin
                    resp_data <= mem_err ? '0 : mem_data;
                    resp_err  <= mem_err;
                end
                ST_RESP: ;
            endcase
        end
    end

    // Next-state logic
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:   if (fetch_req) state_n = bypass ? ST_BYPASS : (hit ? ST_RESP : ST_FILL);
            ST_FILL:   if (fill_last) state_n = ST_RESP;
            ST_BYPASS: if (mem_ready) state_n = ST_RESP;
            ST_RESP:   state_n = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        fetch_ack    = (state == ST_RESP);
        fetch_data   = resp_data;
        fetch_buserr = (state == ST_RESP) && resp_err;
        mem_req      = (state == ST_FILL) || (state == ST_BYPASS);
        mem_addr     = (state == ST_FILL) ? {req_addr[ADDR_W-1:LSB], word_cnt, 2'b00} : req_addr;
        tag_we       = 1'b0;
        tag_widx     = req_addr[LSB+LINE_IDX_W-1:LSB];
        tag_wval     = '1;
        if (take_miss) begin
            tag_we   = 1'b1;
            tag_widx = fetch_addr[LSB+LINE_IDX_W-1:LSB];
        end else if (state == ST_FILL && mem_ready && !mem_err && word_cnt == LAST_OFF) begin
            tag_we   = 1'b1;
            tag_wval = req_addr;
        end
        data_we    = (state == ST_FILL) && mem_ready && !mem_err;
        data_widx  = req_addr[LSB+LINE_IDX_W-1:LSB];
        data_woff  = word_cnt;
        data_wdata = mem_data;
    end

    p_ack_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_ack |=> !fetch_ack);
    p_hit_ack_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && fetch_req && !bypass && hit) |=> fetch_ack);
    p_no_mem_on_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_ack |-> !mem_req);
    p_err_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_buserr |-> (fetch_ack && fetch_data == '0));
    p_fill_ascend_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FILL && mem_ready && !mem_err && mem_addr[LSB-1:2] != LAST_OFF)
        |=> mem_addr == $past(mem_addr) + ADDR_W'(4));
    p_addr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> $stable(mem_addr));
    p_bypass_untouched_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BYPASS) |-> (!tag_we && !data_we));
endmodule

// File: rtl/icache_partial_fill.sv
module icache_partial_fill #(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int LINE_IDX_W = 8,
    parameter int WORD_SEL_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_req,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic              bypass,
    input  logic              isolate,
    output logic              fetch_ack,
    output logic [DATA_W-1:0] fetch_data,
    output logic              fetch_buserr,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ready,
    input  logic [DATA_W-1:0] mem_data,
    input  logic              mem_err
);
    localparam int LSB = WORD_SEL_W + 2;

    logic                  hit;
    logic [DATA_W-1:0]     rd_word;
    logic                  tag_we, data_we;
    logic [LINE_IDX_W-1:0] tag_widx, data_widx;
    logic [ADDR_W-1:0]     tag_wval;
    logic [WORD_SEL_W-1:0] data_woff;
    logic [DATA_W-1:0]     data_wdata;

    icache_tag_store #(.ADDR_W(ADDR_W), .LINE_IDX_W(LINE_IDX_W), .WORD_SEL_W(WORD_SEL_W)) u_tags (
        .clk(clk), .rst_n(rst_n), .isolate(isolate), .lk_addr(fetch_addr), .hit(hit),
        .wr_en(tag_we), .wr_idx(tag_widx), .wr_tag(tag_wval)
    );

    icache_data_store #(.DATA_W(DATA_W), .LINE_IDX_W(LINE_IDX_W), .WORD_SEL_W(WORD_SEL_W)) u_data (
        .clk(clk), .rst_n(rst_n), .isolate(isolate),
        .wr_en(data_we), .wr_idx(data_widx), .wr_off(data_woff), .wr_data(data_wdata),
        .rd_idx(fetch_addr[LSB+LINE_IDX_W-1:LSB]), .rd_off(fetch_addr[LSB-1:2]), .rd_data(rd_word)
    );

    icache_fill_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINE_IDX_W(LINE_IDX_W), .WORD_SEL_W(WORD_SEL_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .fetch_addr(fetch_addr), .bypass(bypass),
        .hit(hit), .rd_word(rd_word), .fetch_ack(fetch_ack), .fetch_data(fetch_data),
        .fetch_buserr(fetch_buserr), .mem_req(mem_req), .mem_addr(mem_addr), .mem_ready(mem_ready),
        .mem_data(mem_data), .mem_err(mem_err), .tag_we(tag_we), .tag_widx(tag_widx),
        .tag_wval(tag_wval), .data_we(data_we), .data_widx(data_widx), .data_woff(data_woff),
        .data_wdata(data_wdata)
    );
endmodule

// File: tb/icache_partial_fill_tb_top.sv
`timescale 1ns/1ps
module icache_partial_fill_tb_top;
    localparam int AW = 32;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fetch_req = 1'b0;
    logic [AW-1:0] fetch_addr = '0;
    logic          bypass = 1'b0;
    logic          isolate = 1'b0;
    logic          fetch_ack, fetch_buserr, mem_req;
    logic [DW-1:0] fetch_data;
    logic [AW-1:0] mem_addr;
    logic          mem_ready = 1'b0;
    logic [DW-1:0] mem_data = '0;
    logic          mem_err = 1'b0;

    int n_checks = 0;
    int n_fail   = 0;
    int rd_count = 0;
    logic [AW-1:0] first_rd = '0;

    typedef struct {
        logic [DW-1:0] data;
        logic          err;
        string         rq;
    } exp_item_t;
    exp_item_t exp_q[$];

    always #2 clk = ~clk;

    icache_partial_fill #(.ADDR_W(AW), .DATA_W(DW), .LINE_IDX_W(4), .WORD_SEL_W(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .fetch_addr(fetch_addr), .bypass(bypass),
        .isolate(isolate), .fetch_ack(fetch_ack), .fetch_data(fetch_data), .fetch_buserr(fetch_buserr),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ready(mem_ready), .mem_data(mem_data), .mem_err(mem_err)
    );

    function automatic logic [DW-1:0] memf(input logic [AW-1:0] a);
        return a ^ 32'h5A5A_0F0F;
    endfunction
    function automatic logic unmapped(input logic [AW-1:0] a);
        return a[31:28] == 4'hB;
    endfunction

    task automatic check(input bit ok, input string rq, input string what,
                         input logic [AW-1:0] act, input logic [AW-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    // Memory model: one idle cycle between returned words
    always @(negedge clk) begin
        if (!rst_n) mem_ready <= 1'b0;
        else begin
            mem_ready <= mem_req && !mem_ready;
            mem_data  <= unmapped(mem_addr) ? '0 : memf(mem_addr);
            mem_err   <= unmapped(mem_addr);
        end
    end

    // Memory read monitor
    always @(posedge clk) begin
        if (rst_n && mem_req && mem_ready) begin
            if (rd_count == 0) first_rd = mem_addr;
            rd_count = rd_count + 1;
        end
    end

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && fetch_ack) begin
            if (exp_q.size() == 0) check(1'b0, "R10", "unexpected ack", 32'd1, 32'd0);
            else begin
                exp_item_t it;
                it = exp_q.pop_front();
                check(fetch_data == it.data, it.rq, "fetch_data", fetch_data, it.data);
                check(fetch_buserr == it.err, it.rq, "fetch_buserr", {31'd0, fetch_buserr}, {31'd0, it.err});
            end
        end
    end

    // Driver: called at a negedge with the design idle
    task automatic do_fetch(input logic [AW-1:0] a, input bit byp, input int exp_reads, input string rq);
        exp_item_t it;
        int lat;
        int exp_lat;
        it.err  = unmapped(a);
        it.data = it.err ? '0 : memf(a);
        it.rq   = rq;
        exp_q.push_back(it);
        exp_lat = (exp_reads == 0) ? 1 : 2 * exp_reads;
        rd_count   = 0;
        fetch_req  = 1'b1;
        fetch_addr = a;
        bypass     = byp;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!fetch_ack && lat < 200);
        fetch_req = 1'b0;
        bypass    = 1'b0;
        check(lat == exp_lat, rq, "ack latency", lat, exp_lat);
        check(rd_count == exp_reads, rq, "memory reads", rd_count, exp_reads);
        if (exp_reads > 0) check(first_rd == a, rq, "first read address", first_rd, a);
        @(negedge clk);
        check(!fetch_ack, "R10", "ack pulse width", {31'd0, fetch_ack}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8 reset state
        check(!fetch_ack && !fetch_buserr && !mem_req, "R8", "idle outputs after reset",
              {29'd0, fetch_ack, fetch_buserr, mem_req}, 32'd0);
        do_fetch(32'hFFFF_FFFC, 0, 1, "R8");   // reset tags never hit
        do_fetch(32'h0000_0100, 0, 4, "R5");   // full-line fill, R3
        do_fetch(32'h0000_010C, 0, 0, "R2");
        do_fetch(32'h0000_0108, 0, 0, "R2");
        do_fetch(32'h0000_0208, 0, 2, "R3");   // same line, partial fill
        do_fetch(32'h0000_020C, 0, 0, "R4");   // later word hits
        do_fetch(32'h0000_0200, 0, 4, "R4");   // earlier word misses
        do_fetch(32'h0000_0204, 0, 0, "R4");
        do_fetch(32'h0000_0100, 0, 4, "R1");   // conflict eviction
        do_fetch(32'h0000_0134, 0, 3, "R3");
        do_fetch(32'h0000_0138, 0, 0, "R2");
        do_fetch(32'h0000_0104, 1, 1, "R9");   // bypass of resident word
        do_fetch(32'h0000_0104, 0, 0, "R9");
        do_fetch(32'h0000_0300, 1, 1, "R9");   // bypass of conflicting line
        do_fetch(32'h0000_0100, 0, 0, "R9");
        do_fetch(32'h0000_0300, 0, 4, "R9");   // bypass left no line behind
        do_fetch(32'hB000_0040, 0, 1, "R6");
        do_fetch(32'hB000_0040, 0, 1, "R6");   // not cached after error
        do_fetch(32'h0000_0134, 0, 0, "R7");   // resident before isolate
        isolate = 1'b1;
        @(negedge clk);
        isolate = 1'b0;
        @(negedge clk);
        do_fetch(32'h0000_0134, 0, 3, "R7");
        do_fetch(32'h0000_0308, 0, 2, "R7");
        do_fetch(32'h0000_00F0, 0, 4, "R1");
        do_fetch(32'h0000_00FC, 0, 0, "R1");
        do_fetch(32'h0000_01F0, 0, 4, "R1");
        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R10", "pending scoreboard items", exp_q.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL R10 watchdog: actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule